// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the device side of an asynchronous page-mode DRAM interface. A fast clock samples the active-low row strobe, column strobe, write enable and output enable. From the order of the strobe edges it works out what kind of memory cycle the controller is running. It produces single-cycle enables for the internal row and column address latches, a write strobe and a refresh-counter advance. It also produces the enable for the data-output drivers.

The block holds the row counter used for refresh cycles in which the column strobe goes low before the row strobe. It recognises a refresh hidden behind a read. It enters an autonomous self-refresh state when the row strobe stays low long enough in a refresh cycle. The memory array, the sense timing and the pad drivers belong to neighbouring logic. The outputs are meant to be checked by a scoreboard or to drive a behavioural array model.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, cycleType is 0 (idle), oeDrive, selfRefresh and every pulse output are 0, and refreshRow is 0.
- R2: A row-strobe fall with the column strobe high gives exactly one rowLatch pulse and no colLatch or refreshInc pulse in the same cycle. rowAddr takes the address. cycleType becomes 5 (row-only refresh), and oeDrive stays 0 while no column strobe follows.
- R3: A row-strobe fall while the column strobe is already low is a counter refresh. The same holds when both falls reach the block in the same sample. cycleType becomes 6, refreshInc pulses once, and refreshRow advances by ROW_STEP modulo 2^ROW_W. There is no rowLatch or colLatch, and rowAddr is unchanged.
- R4: A column-strobe fall with write enable low is an early write. cycleType becomes 2, and writeStrobe and colLatch pulse once each. colAddr takes the address, and oeDrive stays 0 even when output enable is low.
- R5: A column-strobe fall with write enable high is a read (cycleType 1). colAddr takes the address, and oeDrive is 1 while both the column strobe and output enable are low.
- R6: Write enable falling while the column strobe is low in a read, before any data was driven, is a late write. cycleType becomes 3 and writeStrobe pulses once. oeDrive stays 0 afterwards, even when output enable goes low.
- R7: Write enable falling in a read after data was driven is a read-modify-write. cycleType becomes 4 and oeDrive becomes 0.
- R8: In a read, raising output enable with the column strobe low releases the outputs (oeDrive 0). Lowering it again re-drives the held data (oeDrive 1).
- R9: Raising the column strobe releases the outputs whatever output enable does, and it clears the held read data.
- R10: After a read with the column strobe held low, raising and lowering the row strobe is a hidden refresh. cycleType becomes 7 and refreshRow advances by ROW_STEP, while oeDrive stays 1 throughout.
- R11: When the row strobe stays low for SELF_CYCLES samples in a refresh cycle, selfRefresh becomes 1 and cycleType becomes 8. refreshInc then pulses once every REF_INTERVAL cycles, each pulse advancing refreshRow by ROW_STEP. Raising the row strobe clears selfRefresh.
- R12: Each further column-strobe fall while the row strobe stays low latches a new column and classifies the access again. No new rowLatch pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low, asynchronous |
| casN | input | 1 | Column strobe, active low, asynchronous |
| weN | input | 1 | Write enable, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| addr | input | ROW_W | Multiplexed row/column address |
| cycleType | output | 4 | Classified cycle code (codes in R1 to R11) |
| rowLatch | output | 1 | One-cycle row address latch enable |
| colLatch | output | 1 | One-cycle column address latch enable |
| writeStrobe | output | 1 | One-cycle write enable to the array |
| refreshInc | output | 1 | One-cycle refresh of the counter row |
| oeDrive | output | 1 | Data-output driver enable |
| selfRefresh | output | 1 | Self-refresh state active |
| refreshRow | output | ROW_W | Internal refresh row counter |
| rowAddr | output | ROW_W | Latched row address |
| colAddr | output | ROW_W | Latched column address |

## Verification
The assertions assume that the strobes and the address stay stable for at least the synchronizer depth plus one sample around each edge. They also assume that the address is valid whenever a strobe falls, so the classification is never taken from a half-sampled change. The stimulus changes inputs only on falling clock edges and holds every level for several samples before the next change. It also ends refresh cycles by raising the row strobe before the column strobe, so that no cycle is entered by accident.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [3:0] {
    CY_IDLE    = 4'd0,
    CY_READ    = 4'd1,
    CY_EWRITE  = 4'd2,
    CY_LWRITE  = 4'd3,
    CY_RMW     = 4'd4,
    CY_RASONLY = 4'd5,
    CY_CBR     = 4'd6,
    CY_HIDDEN  = 4'd7,
    CY_SELF    = 4'd8
  } cycle_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_ACCESS, PH_REFRESH, PH_SELF
  } phase_e;

  typedef struct packed {
    logic rowLatch;
    logic colLatch;
    logic refreshInc;
    logic setValid;
    logic clrValid;
    logic casLow;
    logic oeLow;
  } strobe_t;
endpackage

// File: rtl/dram_dec_sync.sv
module dram_dec_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/dram_dec_ctrl.sv
module dram_dec_ctrl
  import dram_dec_pkg::*;
#(
  parameter int SELF_CYCLES = 10000,
  parameter int REF_INTERVAL = 1563
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rasS,
  input  logic    casS,
  input  logic    weS,
  input  logic    oeS,
  input  logic    dataValid,
  input  logic    oeDrive,
  output strobe_t strb,
  output logic    writeStrobe,
  output cycle_e  cycleType,
  output logic    selfRefresh
);
  localparam int CNT_MAX = (SELF_CYCLES > REF_INTERVAL) ? SELF_CYCLES : REF_INTERVAL;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SELF_LAST = CNT_W'(SELF_CYCLES - 1);
  localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(REF_INTERVAL - 1);

  logic rasP, casP, weP;
  logic rasFall, rasRise, casFall, casRise, weFall;
  phase_e phase, phaseNext;
  cycle_e typeNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic readSeen, readSeenNext;
  logic wrNext;
  strobe_t strbNext;

  assign rasFall = rasP & ~rasS;
  assign rasRise = ~rasP & rasS;
  assign casFall = casP & ~casS;
  assign casRise = ~casP & casS;
  assign weFall  = weP & ~weS;

  always_comb begin
    phaseNext = phase;
    typeNext = cycleType;
    cntNext = cnt;
    readSeenNext = readSeen | oeDrive;
    wrNext = 1'b0;
    strbNext = '0;
    strbNext.casLow = ~casS;
    strbNext.oeLow = ~oeS;
    if (casRise) strbNext.clrValid = 1'b1;
    if (rasFall) begin
      cntNext = '0;
      if (!casS) begin
        phaseNext = PH_REFRESH;
        typeNext = dataValid ? CY_HIDDEN : CY_CBR;
        strbNext.refreshInc = 1'b1;
      end else begin
        phaseNext = PH_ACCESS;
        typeNext = CY_RASONLY;
        strbNext.rowLatch = 1'b1;
      end
    end else if (rasRise) begin
      phaseNext = PH_IDLE;
    end else begin
      case (phase)
        PH_ACCESS: begin
          if (casFall) begin
            strbNext.colLatch = 1'b1;
            readSeenNext = 1'b0;
            if (!weS) begin
              typeNext = CY_EWRITE;
              wrNext = 1'b1;
            end else begin
              typeNext = CY_READ;
              strbNext.setValid = 1'b1;
            end
          end else if (weFall && !casS && cycleType == CY_READ) begin
            typeNext = readSeen ? CY_RMW : CY_LWRITE;
            wrNext = 1'b1;
            strbNext.clrValid = 1'b1;
          end
        end
        PH_REFRESH: begin
          if (cnt == SELF_LAST) begin
            phaseNext = PH_SELF;
            typeNext = CY_SELF;
            cntNext = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        PH_SELF: begin
          if (cnt == TICK_LAST) begin
            cntNext = '0;
            strbNext.refreshInc = 1'b1;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasP <= 1'b1;
      casP <= 1'b1;
      weP <= 1'b1;
      phase <= PH_IDLE;
      cycleType <= CY_IDLE;
      cnt <= '0;
      readSeen <= 1'b0;
    end else begin
      rasP <= rasS;
      casP <= casS;
      weP <= weS;
      phase <= phaseNext;
      cycleType <= typeNext;
      cnt <= cntNext;
      readSeen <= readSeenNext;
    end
  end

  assign strb = strbNext;
  assign writeStrobe = wrNext;
  assign selfRefresh = (phase == PH_SELF);
endmodule

// File: rtl/dram_dec_data.sv
module dram_dec_data
  import dram_dec_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int ROW_STEP = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [ROW_W-1:0] addrS,
  output logic [ROW_W-1:0] rowAddr,
  output logic [ROW_W-1:0] colAddr,
  output logic [ROW_W-1:0] refreshRow,
  output logic             dataValid,
  output logic             oeDrive
);
  localparam logic [ROW_W-1:0] STEP = ROW_W'(ROW_STEP);
  logic validNext;

  always_comb begin
    if (strb.setValid) validNext = 1'b1;
    else if (strb.clrValid) validNext = 1'b0;
    else validNext = dataValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowAddr <= '0;
      colAddr <= '0;
      refreshRow <= '0;
      dataValid <= 1'b0;
      oeDrive <= 1'b0;
    end else begin
      if (strb.rowLatch) rowAddr <= addrS;
      if (strb.colLatch) colAddr <= addrS;
      if (strb.refreshInc) refreshRow <= refreshRow + STEP;
      dataValid <= validNext;
      oeDrive <= validNext & strb.casLow & strb.oeLow;
    end
  end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_dec_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int ROW_STEP = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SELF_CYCLES = 10000,
  parameter int REF_INTERVAL = 1563
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic             oeN,
  input  logic [ROW_W-1:0] addr,
  output logic [3:0]       cycleType,
  output logic             rowLatch,
  output logic             colLatch,
  output logic             writeStrobe,
  output logic             refreshInc,
  output logic             oeDrive,
  output logic             selfRefresh,
  output logic [ROW_W-1:0] refreshRow,
  output logic [ROW_W-1:0] rowAddr,
  output logic [ROW_W-1:0] colAddr
);
  localparam int SW = 4 + ROW_W;
  localparam logic [SW-1:0] SYNC_RST = {4'b1111, {ROW_W{1'b0}}};

  logic [SW-1:0] syncOut;
  logic rasS, casS, weS, oeS;
  logic [ROW_W-1:0] addrS;
  strobe_t strb;
  cycle_e cyType;
  logic dataValid;

  dram_dec_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .din({rasN, casN, weN, oeN, addr}), .dout(syncOut)
  );

  assign {rasS, casS, weS, oeS, addrS} = syncOut;

  dram_dec_ctrl #(.SELF_CYCLES(SELF_CYCLES), .REF_INTERVAL(REF_INTERVAL)) u_ctrl (
    .clk(clk), .rstN(rstN), .rasS(rasS), .casS(casS), .weS(weS), .oeS(oeS),
    .dataValid(dataValid), .oeDrive(oeDrive), .strb(strb),
    .writeStrobe(writeStrobe), .cycleType(cyType), .selfRefresh(selfRefresh)
  );

  dram_dec_data #(.ROW_W(ROW_W), .ROW_STEP(ROW_STEP)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .addrS(addrS),
    .rowAddr(rowAddr), .colAddr(colAddr), .refreshRow(refreshRow),
    .dataValid(dataValid), .oeDrive(oeDrive)
  );

  assign cycleType = cyType;
  assign rowLatch = strb.rowLatch;
  assign colLatch = strb.colLatch;
  assign refreshInc = strb.refreshInc;
endmodule

// File: rtl/dram_cycle_decoder_chk.sv
module dram_cycle_decoder_chk
  import dram_dec_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int ROW_STEP = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       cycleType,
  input logic             rowLatch,
  input logic             colLatch,
  input logic             writeStrobe,
  input logic             refreshInc,
  input logic             oeDrive,
  input logic             selfRefresh,
  input logic [ROW_W-1:0] refreshRow,
  input strobe_t          strb
);
  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rowLatch, colLatch, refreshInc}));

  assert_row_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    refreshInc |=> refreshRow == $past(refreshRow) + ROW_W'(ROW_STEP));

  assert_ewrite_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cycleType == CY_EWRITE) |-> !oeDrive);

  assert_write_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    writeStrobe |=> !oeDrive);

  assert_cas_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.casLow |=> !oeDrive);

  assert_self_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    selfRefresh |-> (cycleType == CY_SELF));
endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk #(.ROW_W(ROW_W), .ROW_STEP(ROW_STEP)) u_chk (
  .clk(clk), .rstN(rstN), .cycleType(cycleType), .rowLatch(rowLatch),
  .colLatch(colLatch), .writeStrobe(writeStrobe), .refreshInc(refreshInc),
  .oeDrive(oeDrive), .selfRefresh(selfRefresh), .refreshRow(refreshRow),
  .strb(strb)
);

// File: tb/dram_cycle_decoder_test.sv
module dram_cycle_decoder_test;
  localparam int ROW_W = 13;
  localparam int STEP = 2;
  localparam int SELF_CYC = 40;
  localparam int TICK = 6;

  logic clk = 0, rstN = 0;
  logic rasN = 1, casN = 1, weN = 1, oeN = 1;
  logic [ROW_W-1:0] addr = '0;
  logic [3:0] cycleType;
  logic rowLatch, colLatch, writeStrobe, refreshInc, oeDrive, selfRefresh;
  logic [ROW_W-1:0] refreshRow, rowAddr, colAddr;

  int checks = 0, errors = 0;
  int nRow = 0, nCol = 0, nWr = 0, nRef = 0;
  int sRow, sCol, sWr, sRef;
  logic [ROW_W-1:0] expRow = '0, lastRow = '0;

  always #5 clk = ~clk;

  dram_cycle_decoder #(.ROW_W(ROW_W), .ROW_STEP(STEP), .SYNC_STAGES(2),
    .SELF_CYCLES(SELF_CYC), .REF_INTERVAL(TICK)) uut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .cycleType(cycleType), .rowLatch(rowLatch), .colLatch(colLatch),
    .writeStrobe(writeStrobe), .refreshInc(refreshInc), .oeDrive(oeDrive),
    .selfRefresh(selfRefresh), .refreshRow(refreshRow), .rowAddr(rowAddr),
    .colAddr(colAddr)
  );

  always @(posedge clk) begin
    if (rowLatch) nRow <= nRow + 1;
    if (colLatch) nCol <= nCol + 1;
    if (writeStrobe) nWr <= nWr + 1;
    if (refreshInc) nRef <= nRef + 1;
  end

  // mode(2) oeLow(1) addr(13) expType(4) expDrive(1); mode 0 row-only, 1 read, 2 early write, 3 counter refresh
  localparam logic [20:0] VEC [7] = '{
    {2'd1, 1'b1, 13'h00AB, 4'd1, 1'b1},
    {2'd2, 1'b1, 13'h0155, 4'd2, 1'b0},
    {2'd3, 1'b1, 13'h1FFF, 4'd6, 1'b0},
    {2'd0, 1'b0, 13'h00F0, 4'd5, 1'b0},
    {2'd1, 1'b0, 13'h1234, 4'd1, 1'b0},
    {2'd3, 1'b0, 13'h0777, 4'd6, 1'b0},
    {2'd2, 1'b0, 13'h0ABC, 4'd2, 1'b0}
  };

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    sRow = nRow; sCol = nCol; sWr = nWr; sRef = nRef;
  endtask

  task automatic idle();
    rasN = 1; wt(3); casN = 1; weN = 1; oeN = 1; wt(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wt(5); rstN = 1; wt(3);
    chk("R1 type", cycleType, 0);
    chk("R1 drive", oeDrive, 0);
    chk("R1 self", selfRefresh, 0);
    chk("R1 row", refreshRow, 0);
    chk("R1 pulses", nRow + nCol + nWr + nRef, 0);

    for (int i = 0; i < 7; i++) begin
      logic [1:0] md;
      logic [ROW_W-1:0] a, c;
      md = VEC[i][20:19];
      a = VEC[i][17:5];
      c = a ^ 13'h1555;
      snap();
      addr = a;
      if (md == 2'd3) begin
        casN = 0; wt(3); rasN = 0; wt(6);
        expRow = expRow + ROW_W'(STEP);
        chk("R3 type", cycleType, VEC[i][4:1]);
        chk("R3 counter", refreshRow, expRow);
        chk("R3 rowAddr kept", rowAddr, lastRow);
        chk("R3 no latch", (nRow - sRow) + (nCol - sCol), 0);
        chk("R3 one inc", nRef - sRef, 1);
      end else begin
        rasN = 0; wt(6);
        chk("R2 rowAddr", rowAddr, a);
        chk("R2 one rowLatch", nRow - sRow, 1);
        chk("R2 type", cycleType, 5);
        chk("R2 drive", oeDrive, 0);
        lastRow = a;
        if (md != 2'd0) begin
          addr = c;
          weN = (md == 2'd2) ? 1'b0 : 1'b1;
          oeN = ~VEC[i][18];
          casN = 0; wt(6);
          chk(md == 2'd2 ? "R4 type" : "R5 type", cycleType, VEC[i][4:1]);
          chk(md == 2'd2 ? "R4 drive" : "R5 drive", oeDrive, VEC[i][0]);
          chk(md == 2'd2 ? "R4 colAddr" : "R5 colAddr", colAddr, c);
          chk(md == 2'd2 ? "R4 strobe" : "R5 no strobe", nWr - sWr, (md == 2'd2) ? 1 : 0);
        end
      end
      idle();
    end

    // R3: both strobes fall in the same sample
    snap();
    rasN = 0; casN = 0; wt(6);
    expRow = expRow + ROW_W'(STEP);
    chk("R3 same-sample type", cycleType, 6);
    chk("R3 same-sample no col", nCol - sCol, 0);
    chk("R3 same-sample counter", refreshRow, expRow);
    idle();

    // R8, R9, R12, R7: page mode with output enable toggling, then read-modify-write
    snap();
    addr = 13'h0321; rasN = 0; wt(6);
    addr = 13'h0011; casN = 0; wt(6);
    chk("R5 no drive oe high", oeDrive, 0);
    oeN = 0; wt(6);
    chk("R8 drive", oeDrive, 1);
    oeN = 1; wt(6);
    chk("R8 release", oeDrive, 0);
    oeN = 0; wt(6);
    chk("R8 redrive", oeDrive, 1);
    casN = 1; wt(6);
    chk("R9 cas release", oeDrive, 0);
    addr = 13'h0022; casN = 0; wt(6);
    chk("R12 type", cycleType, 1);
    chk("R12 colAddr", colAddr, 13'h0022);
    chk("R12 no new row", nRow - sRow, 1);
    chk("R12 col count", nCol - sCol, 2);
    chk("R12 drive", oeDrive, 1);
    oeN = 1; wt(4); weN = 0; wt(6);
    chk("R7 type", cycleType, 4);
    chk("R7 drive", oeDrive, 0);
    chk("R7 strobe", nWr - sWr, 1);
    idle();

    // R6: late write
    snap();
    rasN = 0; wt(6); casN = 0; wt(6); weN = 0; wt(6);
    chk("R6 type", cycleType, 3);
    chk("R6 strobe", nWr - sWr, 1);
    oeN = 0; wt(6);
    chk("R6 no drive", oeDrive, 0);
    idle();

    // R10: hidden refresh
    rasN = 0; wt(6); oeN = 0; casN = 0; wt(6);
    chk("R10 read drive", oeDrive, 1);
    rasN = 1; wt(6);
    chk("R10 drive ras high", oeDrive, 1);
    rasN = 0; wt(6);
    expRow = expRow + ROW_W'(STEP);
    chk("R10 type", cycleType, 7);
    chk("R10 drive kept", oeDrive, 1);
    chk("R10 counter", refreshRow, expRow);
    rasN = 1; wt(4); casN = 1; wt(6);
    chk("R9 release oe low", oeDrive, 0);
    idle();

    // R11: self refresh
    casN = 0; wt(3); rasN = 0; wt(SELF_CYC / 2);
    chk("R11 not yet self", selfRefresh, 0);
    wt(SELF_CYC);
    chk("R11 self", selfRefresh, 1);
    chk("R11 type", cycleType, 8);
    begin
      logic [ROW_W-1:0] r0;
      r0 = refreshRow; snap();
      wt(4 * TICK);
      chk("R11 tick count", nRef - sRef, 4);
      chk("R11 counter", refreshRow, r0 + ROW_W'(4 * STEP));
    end
    rasN = 1; wt(6);
    chk("R11 exit", selfRefresh, 0);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule